// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits between the request side of a multi-channel DMA controller and a small pool of move engines. Every channel owns a sticky pending flag that can be raised from four places: a software request bit, a hardware trigger line, a chained trigger issued when another channel (or the same one) finishes, and an auto-start pulse issued after a linked-list reload. Each cycle the arbiter looks at all channels that are pending and not already being served, and hands the highest-numbered ones to whichever engines are idle.

Any engine may serve any channel. When two engines are free, the two strongest candidates are dispatched in the same cycle, and the lower-indexed engine takes the higher channel. An engine reports the end of a transaction with a one-cycle done pulse. The arbiter then frees the engine, clears the channel's pending flag, raises that channel's own completion interrupt for one cycle, and, if chaining is enabled for the channel, raises the pending flag of the configured target channel. A request that arrives while its channel is in service is remembered and leads to another service round.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, no channel is pending, every engine is idle, no start pulse and no interrupt is raised.
- R2: A one-cycle pulse on any of the software, hardware or auto-start request bits of a channel sets that channel's bit of `pend_o` on the clock edge that samples it. The bit then stays set with no further request.
- R3: On the edge after a channel appears eligible (pending and not in service) while an engine is idle, an engine becomes busy with that channel and its start bit is high for one cycle. Among eligible channels, the highest number is dispatched first.
- R4: When both engines are idle, the two highest eligible channels are dispatched on the same edge. Engine 0 takes the higher channel and engine 1 the lower.
- R5: A channel is never held by two engines at once. A lone eligible channel occupies only one engine.
- R6: A done pulse from a busy engine frees it on the sampling edge and clears the channel's pending bit. The channel's bit of `ch_irq_o` is high for exactly the next cycle.
- R7: A request for a channel that is already dispatched is kept. After that service completes, the channel stays pending and is dispatched again one cycle later.
- R8: When a channel completes with its chain enable set, the channel selected by its 3-bit field in `chain_tgt_i` (bits [3c+2:3c] for channel c) becomes pending. The target may be the same channel.
- R9: A done pulse from an idle engine has no effect on pending bits, interrupts or engine state.
- R10: While an engine stays busy its channel number does not change. A freed engine can take new work on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_req_i | input | NCH | Software request pulses, one per channel |
| hw_req_i | input | NCH | Hardware trigger pulses, one per channel |
| auto_req_i | input | NCH | Auto-start pulses after a linked-list reload |
| chain_en_i | input | NCH | Per-channel enable of the completion chain trigger |
| chain_tgt_i | input | NCH*CW | Per-channel chain target channel number, CW bits each |
| eng_done_i | input | NENG | One-cycle completion pulse from each engine |
| pend_o | output | NCH | Pending flag of each channel |
| eng_busy_o | output | NENG | Engine busy flags |
| eng_ch_o | output | NENG*CW | Channel held by each engine, CW bits each |
| eng_start_o | output | NENG | One-cycle pulse when an engine is given a channel |
| ch_irq_o | output | NCH | One-cycle completion interrupt per channel |

## Verification
The bench builds the block with its defaults of eight channels and two engines, so CW is 3. With two engines, pairwise dispatch, ordering between engines and the case of one idle and one busy engine can all be reached. Eight channels leave room for a chain target different from the source, for a self-chain, and for a request that lands on a channel already in service while other channels compete for the same engines.

// File: rtl/dmaarb_pkg.sv
package dmaarb_pkg;
  localparam int unsigned NCH_DEF  = 8;
  localparam int unsigned NENG_DEF = 2;

  typedef enum logic {
    SLOT_IDLE = 1'b0,
    SLOT_BUSY = 1'b1
  } slot_state_e;
endpackage

// File: rtl/dmaarb_pend.sv
module dmaarb_pend #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] raise_i,
  input  logic [NCH-1:0] busy_ch_i,
  input  logic [NCH-1:0] assign_i,
  input  logic [NCH-1:0] done_ch_i,
  output logic [NCH-1:0] pend_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic pend_q, pend_d;
    logic rearm_q, rearm_d;
    logic upd_en;

    always_comb begin
      pend_d  = pend_q;
      rearm_d = rearm_q;
      if (done_ch_i[c]) begin
        pend_d  = rearm_q | raise_i[c];
        rearm_d = 1'b0;
      end else if (raise_i[c]) begin
        pend_d = 1'b1;
        if (busy_ch_i[c] || assign_i[c]) rearm_d = 1'b1;
      end
    end

    assign upd_en = done_ch_i[c] | raise_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q  <= 1'b0;
        rearm_q <= 1'b0;
      end else if (upd_en) begin
        pend_q  <= pend_d;
        rearm_q <= rearm_d;
      end
    end

    assign pend_o[c] = pend_q;
  end
endmodule

// File: rtl/dmaarb_pick.sv
module dmaarb_pick #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NENG = 2,
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]          elig_i,
  input  logic [NENG-1:0]         idle_i,
  output logic [NENG-1:0]         gnt_vld_o,
  output logic [NENG-1:0][CW-1:0] gnt_ch_o,
  output logic [NCH-1:0]          assign_o
);
  logic [NCH-1:0] left;

  always_comb begin
    left      = elig_i;
    gnt_vld_o = '0;
    gnt_ch_o  = '0;
    for (int e = 0; e < NENG; e++) begin
      if (idle_i[e]) begin
        for (int c = NCH - 1; c >= 0; c--) begin
          if (left[c] && !gnt_vld_o[e]) begin
            gnt_vld_o[e] = 1'b1;
            gnt_ch_o[e]  = CW'(c);
          end
        end
        if (gnt_vld_o[e]) left[gnt_ch_o[e]] = 1'b0;
      end
    end
    assign_o = elig_i & ~left;
  end
endmodule

// File: rtl/dmaarb_slot.sv
module dmaarb_slot
  import dmaarb_pkg::*;
#(
  parameter int unsigned NCH = 8,
  localparam int unsigned CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gnt_vld_i,
  input  logic [CW-1:0]  gnt_ch_i,
  input  logic           done_i,
  output logic           busy_o,
  output logic [CW-1:0]  ch_o,
  output logic           start_o,
  output logic [NCH-1:0] held_o,
  output logic [NCH-1:0] fin_o
);
  slot_state_e st_q, st_d;
  logic [CW-1:0] ch_q, ch_d;
  logic start_q, start_d;
  logic st_en;

  always_comb begin
    st_d    = st_q;
    ch_d    = ch_q;
    start_d = 1'b0;
    if (st_q == SLOT_BUSY) begin
      if (done_i) st_d = SLOT_IDLE;
    end else if (gnt_vld_i) begin
      st_d    = SLOT_BUSY;
      ch_d    = gnt_ch_i;
      start_d = 1'b1;
    end
  end

  assign st_en = (st_q == SLOT_BUSY) ? done_i : gnt_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= SLOT_IDLE;
      ch_q <= '0;
    end else if (st_en) begin
      st_q <= st_d;
      ch_q <= ch_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= start_d;
  end

  always_comb begin
    held_o = '0;
    fin_o  = '0;
    if (st_q == SLOT_BUSY) begin
      held_o[ch_q] = 1'b1;
      if (done_i) fin_o[ch_q] = 1'b1;
    end
  end

  assign busy_o  = (st_q == SLOT_BUSY);
  assign ch_o    = ch_q;
  assign start_o = start_q;
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dmaarb_pkg::*;
#(
  parameter int unsigned NCH  = NCH_DEF,
  parameter int unsigned NENG = NENG_DEF,
  localparam int unsigned CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    sw_req_i,
  input  logic [NCH-1:0]    hw_req_i,
  input  logic [NCH-1:0]    auto_req_i,
  input  logic [NCH-1:0]    chain_en_i,
  input  logic [NCH*CW-1:0] chain_tgt_i,
  input  logic [NENG-1:0]   eng_done_i,
  output logic [NCH-1:0]    pend_o,
  output logic [NENG-1:0]   eng_busy_o,
  output logic [NENG*CW-1:0] eng_ch_o,
  output logic [NENG-1:0]   eng_start_o,
  output logic [NCH-1:0]    ch_irq_o
);
  logic [NENG-1:0][NCH-1:0] held_w, fin_w;
  logic [NENG-1:0][CW-1:0]  gnt_ch;
  logic [NENG-1:0]          gnt_vld;
  logic [NCH-1:0] busy_ch, done_ch, chain_set, raise, assign_v, elig;
  logic [NCH-1:0] irq_q, irq_d;

  always_comb begin
    busy_ch = '0;
    done_ch = '0;
    for (int e = 0; e < NENG; e++) begin
      busy_ch = busy_ch | held_w[e];
      done_ch = done_ch | fin_w[e];
    end
  end

  always_comb begin
    chain_set = '0;
    for (int c = 0; c < NCH; c++) begin
      if (done_ch[c] && chain_en_i[c]) chain_set[chain_tgt_i[c*CW +: CW]] = 1'b1;
    end
  end

  assign raise = sw_req_i | hw_req_i | auto_req_i | chain_set;
  assign elig  = pend_o & ~busy_ch;

  dmaarb_pend #(.NCH(NCH)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raise_i   (raise),
    .busy_ch_i (busy_ch),
    .assign_i  (assign_v),
    .done_ch_i (done_ch),
    .pend_o    (pend_o)
  );

  dmaarb_pick #(.NCH(NCH), .NENG(NENG)) u_pick (
    .elig_i    (elig),
    .idle_i    (~eng_busy_o),
    .gnt_vld_o (gnt_vld),
    .gnt_ch_o  (gnt_ch),
    .assign_o  (assign_v)
  );

  for (genvar e = 0; e < NENG; e++) begin : g_slot
    dmaarb_slot #(.NCH(NCH)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gnt_vld_i (gnt_vld[e]),
      .gnt_ch_i  (gnt_ch[e]),
      .done_i    (eng_done_i[e]),
      .busy_o    (eng_busy_o[e]),
      .ch_o      (eng_ch_o[e*CW +: CW]),
      .start_o   (eng_start_o[e]),
      .held_o    (held_w[e]),
      .fin_o     (fin_w[e])
    );
  end

  assign irq_d = done_ch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign ch_irq_o = irq_q;
endmodule

// File: rtl/dmaarb_chk.sv
module dmaarb_chk #(
  parameter int unsigned NCH  = 8,
  parameter int unsigned NENG = 2,
  parameter int unsigned CW   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NCH-1:0]    pend_o,
  input logic [NENG-1:0]   eng_busy_o,
  input logic [NENG*CW-1:0] eng_ch_o,
  input logic [NENG-1:0]   eng_start_o,
  input logic [NCH-1:0]    ch_irq_o
);
  logic dup;
  logic [NCH-1:0] held;
  logic [NCH-1:0] elig;

  always_comb begin
    dup  = 1'b0;
    held = '0;
    for (int e = 0; e < NENG; e++) begin
      if (eng_busy_o[e]) begin
        if (held[eng_ch_o[e*CW +: CW]]) dup = 1'b1;
        held[eng_ch_o[e*CW +: CW]] = 1'b1;
      end
    end
    elig = pend_o & ~held;
  end

  AST_NO_DOUBLE_SERVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup); // R5

  AST_IDLE_TAKES_WORK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|elig) && !(&eng_busy_o)) |=> (|eng_start_o)); // R3

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    AST_START_ON_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_start_o[e] |-> (eng_busy_o[e] && pend_o[eng_ch_o[e*CW +: CW]])); // R3

    AST_CH_HELD_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eng_busy_o[e] && $past(eng_busy_o[e])) |-> $stable(eng_ch_o[e*CW +: CW])); // R10
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_irq_o[c] |=> !ch_irq_o[c]); // R6
  end
endmodule

bind dma_req_arbiter dmaarb_chk #(.NCH(NCH), .NENG(NENG), .CW(CW)) u_dmaarb_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pend_o      (pend_o),
  .eng_busy_o  (eng_busy_o),
  .eng_ch_o    (eng_ch_o),
  .eng_start_o (eng_start_o),
  .ch_irq_o    (ch_irq_o)
);

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
  localparam int NCH = 8;
  localparam int NENG = 2;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0] sw_req, hw_req, auto_req, chain_en;
  logic [NCH*CW-1:0] chain_tgt;
  logic [NENG-1:0] eng_done;
  logic [NCH-1:0] pend, irq;
  logic [NENG-1:0] busy, start;
  logic [NENG*CW-1:0] ech;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  dma_req_arbiter i_dma_req_arbiter (
    .clk_i (clk), .rst_ni (rst_n),
    .sw_req_i (sw_req), .hw_req_i (hw_req), .auto_req_i (auto_req),
    .chain_en_i (chain_en), .chain_tgt_i (chain_tgt), .eng_done_i (eng_done),
    .pend_o (pend), .eng_busy_o (busy), .eng_ch_o (ech),
    .eng_start_o (start), .ch_irq_o (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] chof(input int e);
    return ech[e*CW +: CW];
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic done_pulse(input logic [NENG-1:0] m);
    eng_done = m;
    step();
    eng_done = '0;
  endtask

  task automatic t_reset();
    check("R1 pend", pend, 0);
    check("R1 busy", busy, 0);
    check("R1 start", start, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_single();
    sw_req = 8'h08; step(); sw_req = '0;
    check("R2 pend after sw", pend, 8'h08);
    step();
    check("R3 busy", busy, 2'b01);
    check("R3 ch", chof(0), 3);
    check("R3 start", start, 2'b01);
    step();
    check("R3 start drops", start, 0);
    check("R2 pend held", pend, 8'h08);
    done_pulse(2'b01);
    check("R6 busy cleared", busy, 0);
    check("R6 pend cleared", pend, 0);
    check("R6 irq", irq, 8'h08);
    step();
    check("R6 irq one cycle", irq, 0);
  endtask

  task automatic t_dual();
    hw_req = 8'h25; step(); hw_req = '0;
    check("R2 pend hw", pend, 8'h25);
    step();
    check("R4 busy both", busy, 2'b11);
    check("R4 eng0 high", chof(0), 5);
    check("R4 eng1 next", chof(1), 2);
    check("R4 start both", start, 2'b11);
    done_pulse(2'b10);
    check("R10 eng1 freed", busy, 2'b01);
    check("R6 pend after eng1", pend, 8'h21);
    check("R6 irq ch2", irq, 8'h04);
    step();
    check("R10 eng1 reuse", busy, 2'b11);
    check("R10 eng1 ch0", chof(1), 0);
    check("R10 eng0 steady", chof(0), 5);
    done_pulse(2'b11);
    check("R6 all clear", pend, 0);
    check("R6 irq pair", irq, 8'h21);
    step();
  endtask

  task automatic t_auto_one();
    auto_req = 8'h80; step(); auto_req = '0;
    check("R2 pend auto", pend, 8'h80);
    step();
    check("R5 one engine", busy, 2'b01);
    check("R5 ch7", chof(0), 7);
    step();
    check("R5 still one", busy, 2'b01);
    done_pulse(2'b01);
    check("R6 auto clear", pend, 0);
    step();
  endtask

  task automatic t_rearm();
    sw_req = 8'h10; step(); sw_req = '0;
    step();
    check("R7 first serve", chof(0), 4);
    hw_req = 8'h10; step(); hw_req = '0;
    check("R7 pend during", pend, 8'h10);
    check("R7 no second engine", busy, 2'b01);
    done_pulse(2'b01);
    check("R7 still pending", pend, 8'h10);
    check("R7 irq", irq, 8'h10);
    check("R7 engine idle", busy, 0);
    step();
    check("R7 served again", busy, 2'b01);
    check("R7 ch again", chof(0), 4);
    done_pulse(2'b01);
    check("R7 finally clear", pend, 0);
    step();
  endtask

  task automatic t_chain();
    chain_en = 8'h04;
    chain_tgt = '0;
    chain_tgt[2*CW +: CW] = 3'd6;
    sw_req = 8'h04; step(); sw_req = '0;
    step();
    check("R8 src served", chof(0), 2);
    done_pulse(2'b01);
    check("R8 target pend", pend, 8'h40);
    check("R8 src irq", irq, 8'h04);
    step();
    check("R8 target served", chof(0), 6);
    done_pulse(2'b01);
    check("R8 target clear", pend, 0);
    step();
    chain_en = 8'h20;
    chain_tgt[5*CW +: CW] = 3'd5;
    sw_req = 8'h20; step(); sw_req = '0;
    step();
    done_pulse(2'b01);
    check("R8 self pend", pend, 8'h20);
    step();
    check("R8 self reserved", chof(0), 5);
    check("R8 self busy", busy, 2'b01);
    chain_en = '0;
    done_pulse(2'b01);
    check("R8 self stops", pend, 0);
    step();
  endtask

  task automatic t_stray_done();
    done_pulse(2'b10);
    check("R9 idle pend", pend, 0);
    check("R9 idle busy", busy, 0);
    check("R9 idle irq", irq, 0);
    sw_req = 8'h08; step(); sw_req = '0;
    step();
    done_pulse(2'b10);
    check("R9 eng0 kept", busy, 2'b01);
    check("R9 ch kept", chof(0), 3);
    check("R9 pend kept", pend, 8'h08);
    check("R9 no irq", irq, 0);
    done_pulse(2'b01);
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sw_req = '0; hw_req = '0; auto_req = '0;
    chain_en = '0; chain_tgt = '0; eng_done = '0;
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_single();
    t_dual();
    t_auto_one();
    t_rearm();
    t_chain();
    t_stray_done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule